// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block gives a processor core hardware debug triggers. A bank of instruction breakpoint slots is compared against the address of the instruction about to execute. A second bank of data watchpoint slots is compared against the byte address of each load or store. Each watchpoint slot carries an access-type qualifier that selects reads, writes, both, or nothing. Both hit outputs are combinational in the current cycle. The exception logic can therefore stop the instruction, or suppress the memory access, before it takes effect.

Slots are loaded or emptied through a one-cycle register-write port. In a breakpoint slot, bit 0 of the written address serves as the slot's enable, because instruction addresses never need that bit. When a breakpoint and a watchpoint fire in the same cycle, the breakpoint wins. The watchpoint is then held over and reported in a following cycle. A debug-disable input silences both outputs and drops anything that was held over.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every breakpoint slot is disabled and every watchpoint slot has type disabled, so no fetch or access produces a hit.
- R2: `bp_hit` is high in the same cycle as `fetch_vld` when an enabled breakpoint slot's bits ADDR_W-1..1 equal the same bits of `fetch_pc`; with `fetch_vld` low it stays low.
- R3: Bit 0 of a written breakpoint address is that slot's enable; a slot written with bit 0 = 0 never matches.
- R4: The watchpoint type field `cfg_type` encodes 2'b00 disabled, 2'b01 reads only (`acc_wr`=0), 2'b10 writes only (`acc_wr`=1), 2'b11 reads and writes.
- R5: A watchpoint slot of type disabled never matches, whatever its address.
- R6: `wp_hit` is high in the same cycle as the matching access (`acc_vld` high), before the access commits; with `acc_vld` low no new watchpoint hit arises.
- R7: A watchpoint compares one exact byte address; an access to a neighbouring byte does not match.
- R8: A write with `cfg_we`=1 and `cfg_clr`=1 empties the selected slot (`cfg_kind` 0 = breakpoint, 1 = watchpoint, `cfg_idx` = slot); clearing an already empty slot leaves every other slot unchanged.
- R9: A slot write takes effect from the cycle after `cfg_we`; a fetch in the write cycle itself sees the old contents.
- R10: When a breakpoint hit and a watchpoint hit arise in the same cycle, only `bp_hit` is raised; the watchpoint is held and raises `wp_hit` in the first later cycle without a breakpoint hit.
- R11: While `dbg_off` is high both outputs are low, and any held watchpoint is discarded.
- R12: Slots act in parallel: any one matching slot raises the hit, and `wp_hit` rises only if at least one enabled watchpoint slot matched or one is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_off | input | 1 | Debug disable, forces both hits low |
| cfg_we | input | 1 | Slot write strobe |
| cfg_kind | input | 1 | 0 selects a breakpoint slot, 1 a watchpoint slot |
| cfg_idx | input | SEL_W | Slot index |
| cfg_clr | input | 1 | 1 empties the slot instead of loading it |
| cfg_addr | input | ADDR_W | Address to load (breakpoint bit 0 = enable) |
| cfg_type | input | 2 | Watchpoint access type |
| fetch_vld | input | 1 | Instruction about to execute |
| fetch_pc | input | ADDR_W | Its address |
| acc_vld | input | 1 | Data access presented |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Data byte address |
| bp_hit | output | 1 | Breakpoint hit to exception logic |
| wp_hit | output | 1 | Watchpoint hit to exception logic |

## Verification
Both hits are due in the same cycle as the fetch or access that causes them. Slot writes and the clearing of a held watchpoint become visible one cycle after the stimulus, and a watchpoint deferred behind a breakpoint appears exactly one cycle later. The driver applies each cycle's inputs on the falling edge and queues the outputs expected for that same cycle. The monitor samples a quarter period later, before the next rising edge, so every comparison lands in the cycle the requirement names.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

    typedef enum logic [1:0] {
        WT_OFF = 2'b00,
        WT_RD  = 2'b01,
        WT_WR  = 2'b10,
        WT_RW  = 2'b11
    } wp_kind_e;

    typedef enum logic {
        CFG_BP = 1'b0,
        CFG_WP = 1'b1
    } cfg_tgt_e;

endpackage

// File: rtl/bp_cmp.sv
module bp_cmp #(
    parameter int ADDR_W = 32,
    parameter int NUM    = 4
) (
    input  logic [NUM-1:0][ADDR_W-1:0] slot,
    input  logic                       pc_vld,
    input  logic [ADDR_W-1:0]          pc,
    output logic [NUM-1:0]             hit_vec
);
    // Bit 0 of each slot is its enable; the rest is compared.
    for (genvar g = 0; g < NUM; g++) begin : g_slot
        assign hit_vec[g] = pc_vld && slot[g][0] &&
                            (slot[g][ADDR_W-1:1] == pc[ADDR_W-1:1]);
    end
endmodule

// File: rtl/wp_cmp.sv
module wp_cmp
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM    = 4
) (
    input  logic [NUM-1:0][ADDR_W-1:0] addr,
    input  wp_kind_e [NUM-1:0]         kind,
    input  logic                       acc_vld,
    input  logic                       acc_wr,
    input  logic [ADDR_W-1:0]          acc_addr,
    output logic [NUM-1:0]             hit_vec
);
    for (genvar g = 0; g < NUM; g++) begin : g_slot
        logic kind_ok;
        always_comb begin
            unique case (kind[g])
                WT_RD:   kind_ok = !acc_wr;
                WT_WR:   kind_ok = acc_wr;
                WT_RW:   kind_ok = 1'b1;
                default: kind_ok = 1'b0;
            endcase
        end
        assign hit_vec[g] = acc_vld && kind_ok && (addr[g] == acc_addr);
    end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4,
    parameter int SEL_W  = ((NUM_BP > NUM_WP ? NUM_BP : NUM_WP) > 1) ?
                           $clog2(NUM_BP > NUM_WP ? NUM_BP : NUM_WP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_off,
    input  logic              cfg_we,
    input  logic              cfg_kind,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic              cfg_clr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_type,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              bp_hit,
    output logic              wp_hit
);

    typedef struct packed {
        logic [NUM_BP-1:0][ADDR_W-1:0] bp;
        logic [NUM_WP-1:0][ADDR_W-1:0] wa;
        wp_kind_e [NUM_WP-1:0]         wt;
        logic                          pend;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_BP-1:0] bp_vec;
    logic [NUM_WP-1:0] wp_vec;
    logic              bp_raw;
    logic              wp_raw;
    logic              wp_pend;

    bp_cmp #(.ADDR_W(ADDR_W), .NUM(NUM_BP)) u_bp (
        .slot    (st_q.bp),
        .pc_vld  (fetch_vld),
        .pc      (fetch_pc),
        .hit_vec (bp_vec)
    );

    wp_cmp #(.ADDR_W(ADDR_W), .NUM(NUM_WP)) u_wp (
        .addr     (st_q.wa),
        .kind     (st_q.wt),
        .acc_vld  (acc_vld),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .hit_vec  (wp_vec)
    );

    assign wp_pend = st_q.pend;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_BP; i++) begin
                if (cfg_kind == CFG_BP && cfg_idx == SEL_W'(i)) begin
                    st_d.bp[i] = cfg_clr ? '0 : cfg_addr;
                end
            end
            for (int i = 0; i < NUM_WP; i++) begin
                if (cfg_kind == CFG_WP && cfg_idx == SEL_W'(i)) begin
                    st_d.wa[i] = cfg_clr ? '0 : cfg_addr;
                    st_d.wt[i] = cfg_clr ? WT_OFF : wp_kind_e'(cfg_type);
                end
            end
        end
        bp_raw    = |bp_vec;
        wp_raw    = (|wp_vec) || st_q.pend;
        bp_hit    = bp_raw && !dbg_off;
        wp_hit    = wp_raw && !bp_raw && !dbg_off;
        // Deferred watchpoint waits behind a breakpoint; disable drops it.
        st_d.pend = wp_raw && bp_raw && !dbg_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk (
    input logic clk,
    input logic rst_n,
    input logic dbg_off,
    input logic fetch_vld,
    input logic acc_vld,
    input logic bp_hit,
    input logic wp_hit,
    input logic wp_pend
);
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_off |-> (!bp_hit && !wp_hit)); // R11
    AST_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_off |=> !wp_pend); // R11
    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !(bp_hit && wp_hit)); // R10
    AST_HOLD_BEHIND_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pend && bp_hit) |=> wp_pend); // R10
    AST_HELD_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pend && !bp_hit && !dbg_off) |-> wp_hit); // R10
    AST_BP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> fetch_vld); // R2
    AST_WP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wp_hit |-> (acc_vld || wp_pend)); // R6
endmodule

bind dbg_match_unit dbg_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_off   (dbg_off),
    .fetch_vld (fetch_vld),
    .acc_vld   (acc_vld),
    .bp_hit    (bp_hit),
    .wp_hit    (wp_hit),
    .wp_pend   (wp_pend)
);

// File: tb/sim_dbg_match_unit.sv
module sim_dbg_match_unit;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_off = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_kind = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_clr = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [1:0]  cfg_type = '0;
    logic        fetch_vld = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        acc_vld = 1'b0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        bp_hit;
    logic        wp_hit;

    typedef struct {
        bit    bp;
        bit    wp;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #(CLK_T/2) clk = ~clk;

    dbg_match_unit u0 (
        .clk(clk), .rst_n(rst_n), .dbg_off(dbg_off),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
        .cfg_clr(cfg_clr), .cfg_addr(cfg_addr), .cfg_type(cfg_type),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .bp_hit(bp_hit), .wp_hit(wp_hit)
    );

    // Driver: one cycle of activity plus the outputs due in that cycle.
    task automatic step(bit fv, logic [31:0] pc, bit av, bit wr,
                        logic [31:0] aa, bit off, bit eb, bit ew, string tag);
        exp_t e;
        @(negedge clk);
        cfg_we    = 1'b0;
        fetch_vld = fv;  fetch_pc = pc;
        acc_vld   = av;  acc_wr   = wr;  acc_addr = aa;
        dbg_off   = off;
        e.bp = eb; e.wp = ew; e.tag = tag;
        q.push_back(e);
    endtask

    // Slot write; probe=1 also fetches the written address (old contents).
    task automatic cfg(bit kind, int idx, bit clr, logic [31:0] a,
                       logic [1:0] ty, bit probe);
        exp_t e;
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_kind  = kind; cfg_idx = 2'(idx); cfg_clr = clr;
        cfg_addr  = a;    cfg_type = ty;
        fetch_vld = probe; fetch_pc = a & 32'hFFFF_FFFE;
        acc_vld   = 1'b0;  dbg_off  = 1'b0;
        e.bp = 0; e.wp = 0; e.tag = "R9";
        q.push_back(e);
    endtask

    // Monitor: compare a quarter period after inputs settle.
    always begin
        exp_t e;
        @(negedge clk);
        #(CLK_T/4);
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (bp_hit !== e.bp || wp_hit !== e.wp) begin
                errors++;
                $display("FAIL %s bp_hit=%b wp_hit=%b expected bp=%b wp=%b",
                         e.tag, bp_hit, wp_hit, e.bp, e.wp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        step(1, 32'h0, 1, 0, 32'h0, 0, 0, 0, "R1");
        step(1, 32'h0, 1, 1, 32'h0, 0, 0, 0, "R1");
        // R9: write bp0 while fetching its address, seen next cycle only
        cfg(0, 0, 0, 32'h0000_0101, 2'b00, 1);
        step(1, 32'h100, 0, 0, 0, 0, 1, 0, "R2");
        step(1, 32'h104, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 32'h100, 0, 0, 0, 0, 0, 0, "R2");
        // R3: enable bit clear
        cfg(0, 1, 0, 32'h0000_0200, 2'b00, 0);
        step(1, 32'h200, 0, 0, 0, 0, 0, 0, "R3");
        // R4 read-only slot
        cfg(1, 0, 0, 32'h1000, 2'b01, 0);
        step(0, 0, 1, 0, 32'h1000, 0, 0, 1, "R4");
        step(0, 0, 1, 1, 32'h1000, 0, 0, 0, "R4");
        step(0, 0, 1, 0, 32'h1001, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 32'h0FFF, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 32'h1000, 0, 0, 0, "R6");
        // R4 write-only and both
        cfg(1, 1, 0, 32'h2000, 2'b10, 0);
        step(0, 0, 1, 1, 32'h2000, 0, 0, 1, "R4");
        step(0, 0, 1, 0, 32'h2000, 0, 0, 0, "R4");
        cfg(1, 2, 0, 32'h3000, 2'b11, 0);
        step(0, 0, 1, 0, 32'h3000, 0, 0, 1, "R4");
        step(0, 0, 1, 1, 32'h3000, 0, 0, 1, "R4");
        // R5 disabled type
        cfg(1, 3, 0, 32'h4000, 2'b00, 0);
        step(0, 0, 1, 0, 32'h4000, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 32'h4000, 0, 0, 0, "R5");
        // R10 priority and deferral
        step(1, 32'h100, 1, 0, 32'h1000, 0, 1, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R10 held through a second breakpoint
        step(1, 32'h100, 1, 0, 32'h1000, 0, 1, 0, "R10");
        step(1, 32'h100, 0, 0, 0, 0, 1, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R10");
        // R11 disable
        step(1, 32'h100, 1, 0, 32'h1000, 1, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 32'h100, 1, 0, 32'h1000, 0, 1, 0, "R11");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        // R8 clear, and clearing an empty slot
        cfg(1, 0, 1, 32'h0, 2'b00, 0);
        step(0, 0, 1, 0, 32'h1000, 0, 0, 0, "R8");
        cfg(1, 0, 1, 32'h0, 2'b00, 0);
        step(0, 0, 1, 1, 32'h2000, 0, 0, 1, "R8");
        step(0, 0, 1, 0, 32'h3000, 0, 0, 1, "R8");
        cfg(0, 0, 1, 32'h0, 2'b00, 0);
        step(1, 32'h100, 0, 0, 0, 0, 0, 0, "R8");
        // R12 several slots in parallel
        cfg(0, 2, 0, 32'h0000_0301, 2'b00, 0);
        cfg(0, 3, 0, 32'h0000_0401, 2'b00, 0);
        step(1, 32'h400, 0, 0, 0, 0, 1, 0, "R12");
        step(1, 32'h300, 0, 0, 0, 0, 1, 0, "R12");
        cfg(1, 0, 0, 32'h2000, 2'b11, 0);
        step(0, 0, 1, 1, 32'h2000, 0, 0, 1, "R12");
        step(0, 0, 1, 0, 32'h2000, 0, 0, 1, "R12");
        step(0, 0, 1, 0, 32'h5000, 0, 0, 0, "R12");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired bp_hit=%b wp_hit=%b expected completion",
                     bp_hit, wp_hit);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule